// File: doc/BRIEF.md
# 32-bit Shifter with Condition Flags

This block is the shift datapath of a processor execute stage. In a single combinational pass it moves a 32-bit operand right with zero fill, right with the sign copied into the vacated bits, or left with zero fill. It returns the shifted word together with four condition flags: carry, overflow, sign and zero. The distance comes from one of two places. It is either the low five bits of a register value, or a 5-bit immediate taken from the instruction word and zero-extended.

The instruction decoder drives the operation select, the amount source and both amount fields. The block's outputs are valid in the same cycle as its inputs, so a register stage after it can capture the result and the flags together. The block has no stream traffic and no state. Every pin is therefore a plain level: there is no valid/ready pair and no back-pressure.

Top module: `shift_flag_unit`

## Requirements
- R1: With `op_sel` = 0 (logical right), `result` is `operand_in` moved right by the effective amount, and the vacated upper bits are zero.
- R2: With `op_sel` = 1 (arithmetic right), `result` is `operand_in` moved right by the effective amount, and every vacated upper bit equals `operand_in[31]`.
- R3: With `op_sel` = 2 (logical left), `result` is `operand_in` moved left by the effective amount, and the vacated lower bits are zero.
- R4: When `amt_from_imm` = 1, the effective amount is `amt_imm` zero-extended (0 to 31). When it is 0, the effective amount is `amt_reg[4:0]`, and `amt_reg[31:5]` has no effect on any output.
- R5: For a nonzero effective amount, `flag_cy` equals the last bit moved out. For right shifts this is `operand_in[amount-1]`; for the left shift it is `operand_in[32-amount]`.
- R6: When the effective amount is zero, `result` equals `operand_in` and `flag_cy` is 0, for every operation.
- R7: `flag_ov` is 0 for every operation and input.
- R8: `flag_s` equals `result[31]`. `flag_z` is 1 exactly when `result` is all zeros.
- R9: With `op_sel` = 3 (reserved), `result` equals `operand_in` and `flag_cy` is 0, whatever the amount.
- R10: All outputs follow the inputs combinationally, within the same cycle, and the block holds no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 2 | Operation: 0 logical right, 1 arithmetic right, 2 logical left, 3 reserved pass |
| operand_in | input | 32 | Value to shift |
| amt_from_imm | input | 1 | 1 selects the immediate amount, 0 selects the register amount |
| amt_reg | input | 32 | Register-supplied amount; only bits 4:0 are used |
| amt_imm | input | 5 | Immediate amount, zero-extended |
| result | output | 32 | Shifted value |
| flag_cy | output | 1 | Last bit moved out; 0 for a zero amount |
| flag_ov | output | 1 | Overflow, always 0 |
| flag_s | output | 1 | Sign of the result |
| flag_z | output | 1 | Result is zero |

## Verification
The block has no registers, so any fault in its internal nets shows at the ports in the same cycle as the stimulus that exposes it. A stage of the log shifter that is stuck or crossed breaks `result` only for amounts that have that stage's bit set. An error in the guard bit at the bottom of the shifter shows only in `flag_cy`. An error in the fill value shows only in the upper bits on arithmetic shifts of negative operands. For these reasons the stimulus covers every amount, both amount sources and both operand signs, and it compares the full result and every flag on each vector.

// File: rtl/shift_flag_pkg.sv
package shift_flag_pkg;
  localparam int unsigned SF_DATA_W = 32;
  localparam int unsigned SF_IMM_W  = 5;

  typedef enum logic [1:0] {
    SH_LSR  = 2'd0,
    SH_ASR  = 2'd1,
    SH_LSL  = 2'd2,
    SH_PASS = 2'd3
  } shift_op_e;
endpackage

// File: rtl/shamt_select.sv
module shamt_select #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 5,
  localparam int unsigned AMT_W = $clog2(DATA_W)
) (
  input  logic              from_imm,
  input  logic [DATA_W-1:0] reg_amt,
  input  logic [IMM_W-1:0]  imm_amt,
  input  logic              force_zero,
  output logic [AMT_W-1:0]  eff_amt
);
  logic [AMT_W-1:0] imm_ext;
  logic             unused_reg_hi;

  // zero-extend or truncate the immediate to the shifter's amount width
  generate
    if (IMM_W >= AMT_W) begin : g_imm_trunc
      assign imm_ext = imm_amt[AMT_W-1:0];
    end else begin : g_imm_zext
      assign imm_ext = {{(AMT_W-IMM_W){1'b0}}, imm_amt};
    end
  endgenerate

  assign unused_reg_hi = ^reg_amt[DATA_W-1:AMT_W];

  always_comb begin
    if (force_zero)    eff_amt = '0;
    else if (from_imm) eff_amt = imm_ext;
    else               eff_amt = reg_amt[AMT_W-1:0];
  end
endmodule

// File: rtl/barrel_core.sv
module barrel_core #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic              fill,
  input  logic [AMT_W-1:0]  amt,
  output logic [DATA_W-1:0] dout,
  output logic              last_out
);
  // one guard bit below the data catches the last bit moved out
  logic [DATA_W:0] stg [0:AMT_W];

  assign stg[0] = {din, 1'b0};

  generate
    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
      localparam int unsigned STEP = 1 << k;
      assign stg[k+1] = amt[k] ? {{STEP{fill}}, stg[k][DATA_W:STEP]} : stg[k];
    end
  endgenerate

  assign dout     = stg[AMT_W][DATA_W:1];
  assign last_out = stg[AMT_W][0];

  always_comb begin
    if (amt == '0) begin
      assert_zero_amount_R6: assert (dout == din && !last_out)
        else $error("zero amount altered data or carry");
    end
  end
endmodule

// File: rtl/flag_gen.sv
module flag_gen #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] res,
  input  logic              carry_in,
  output logic              cy,
  output logic              ov,
  output logic              s,
  output logic              z
);
  assign cy = carry_in;
  assign ov = 1'b0;
  assign s  = res[DATA_W-1];
  assign z  = (res == '0);
endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
  import shift_flag_pkg::*;
#(
  parameter int unsigned DATA_W = SF_DATA_W,
  parameter int unsigned IMM_W  = SF_IMM_W,
  localparam int unsigned AMT_W = $clog2(DATA_W)
) (
  input  logic [1:0]        op_sel,
  input  logic [DATA_W-1:0] operand_in,
  input  logic              amt_from_imm,
  input  logic [DATA_W-1:0] amt_reg,
  input  logic [IMM_W-1:0]  amt_imm,
  output logic [DATA_W-1:0] result,
  output logic              flag_cy,
  output logic              flag_ov,
  output logic              flag_s,
  output logic              flag_z
);
  shift_op_e        op;
  logic [AMT_W-1:0] eff_amt;
  logic [DATA_W-1:0] core_in, core_out, rev_in, rev_out;
  logic             is_left, fill_bit, core_cy;

  assign op       = shift_op_e'(op_sel);
  assign is_left  = (op == SH_LSL);
  assign fill_bit = (op == SH_ASR) & operand_in[DATA_W-1];

  shamt_select #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_amt (
    .from_imm   (amt_from_imm),
    .reg_amt    (amt_reg),
    .imm_amt    (amt_imm),
    .force_zero (op == SH_PASS),
    .eff_amt    (eff_amt)
  );

  // a left shift is a right shift of the bit-reversed word
  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
      assign rev_in[i]  = operand_in[DATA_W-1-i];
      assign rev_out[i] = core_out[DATA_W-1-i];
    end
  endgenerate

  assign core_in = is_left ? rev_in : operand_in;

  barrel_core #(.DATA_W(DATA_W)) u_core (
    .din      (core_in),
    .fill     (fill_bit),
    .amt      (eff_amt),
    .dout     (core_out),
    .last_out (core_cy)
  );

  assign result = is_left ? rev_out : core_out;

  flag_gen #(.DATA_W(DATA_W)) u_flags (
    .res      (result),
    .carry_in (core_cy),
    .cy       (flag_cy),
    .ov       (flag_ov),
    .s        (flag_s),
    .z        (flag_z)
  );

  always_comb begin
    if (op == SH_LSR && eff_amt != '0) begin
      assert_lsr_top_clear_R1: assert (result[DATA_W-1] == 1'b0)
        else $error("logical right left a set top bit");
    end
    if (op == SH_ASR) begin
      assert_asr_sign_kept_R2: assert (result[DATA_W-1] == operand_in[DATA_W-1])
        else $error("arithmetic right lost the sign");
    end
    if (op == SH_LSL && eff_amt != '0) begin
      assert_lsl_low_clear_R3: assert (result[0] == 1'b0)
        else $error("left shift left a set low bit");
    end
    if (op == SH_PASS) begin
      assert_pass_through_R9: assert (result == operand_in && !flag_cy)
        else $error("reserved op altered the operand");
    end
    if (op == SH_LSL && eff_amt != '0) begin
      assert_lsl_carry_R5: assert (flag_cy == operand_in[DATA_W - 32'(eff_amt)])
        else $error("left carry is not the last bit out");
    end
  end
endmodule

// File: tb/shift_flag_unit_tb.sv
module shift_flag_unit_tb;
  logic        clk = 1'b0;
  logic [1:0]  op_sel = '0;
  logic [31:0] operand_in = '0;
  logic        amt_from_imm = 1'b0;
  logic [31:0] amt_reg = '0;
  logic [4:0]  amt_imm = '0;
  logic [31:0] result;
  logic        flag_cy, flag_ov, flag_s, flag_z;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  shift_flag_unit u_dut (
    .op_sel(op_sel), .operand_in(operand_in), .amt_from_imm(amt_from_imm),
    .amt_reg(amt_reg), .amt_imm(amt_imm), .result(result),
    .flag_cy(flag_cy), .flag_ov(flag_ov), .flag_s(flag_s), .flag_z(flag_z)
  );

  // bit-serial reference model: {carry, value}
  function automatic logic [32:0] model(input logic [1:0] op, input logic [31:0] v,
                                        input int n);
    logic [31:0] x = v;
    logic cy = 1'b0;
    if (op == 2'd3) return {1'b0, v};
    for (int i = 0; i < n; i++) begin
      case (op)
        2'd0: begin cy = x[0];  x = {1'b0, x[31:1]}; end
        2'd1: begin cy = x[0];  x = {x[31], x[31:1]}; end
        default: begin cy = x[31]; x = {x[30:0], 1'b0}; end
      endcase
    end
    return {cy, x};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h op=%0d opnd=%h imm_src=%0b reg=%h imm=%0d",
               tag, act, exp, op_sel, operand_in, amt_from_imm, amt_reg, amt_imm);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [31:0] v, input logic src,
                       input logic [31:0] ra, input logic [4:0] ia);
    int n;
    logic [32:0] e;
    string rtag;
    @(negedge clk);
    op_sel = op; operand_in = v; amt_from_imm = src; amt_reg = ra; amt_imm = ia;
    #1;
    n = src ? int'(ia) : int'(ra[4:0]);
    e = model(op, v, n);
    case (op)
      2'd0: rtag = "R1";
      2'd1: rtag = "R2";
      2'd2: rtag = "R3";
      default: rtag = "R9";
    endcase
    if (n == 0) rtag = {rtag, "/R6"};
    rtag = {rtag, "/R4/R10"};
    check(rtag, result, e[31:0]);
    check((n == 0 || op == 2'd3) ? "R6 carry" : "R5 carry", {31'd0, flag_cy}, {31'd0, e[32]});
    check("R7 overflow", {31'd0, flag_ov}, 32'd0);
    check("R8 sign", {31'd0, flag_s}, {31'd0, e[31]});
    check("R8 zero", {31'd0, flag_z}, {31'd0, e[31:0] == 32'd0});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int seed_val;
    seed_val = $urandom(32'h5eed_0042);
    repeat (2) @(posedge clk);
    // reset-state / idle inputs: zero operand, zero amount
    apply(2'd0, 32'h0, 1'b0, 32'h0, 5'd0);
    // R6: zero amount on every op
    for (int op = 0; op < 4; op++) apply(2'(op), 32'hA5A5_F00F, 1'b1, 32'h0, 5'd0);
    // R4: register high bits ignored, immediate selected over register
    apply(2'd0, 32'h8000_0001, 1'b0, 32'hFFFF_FFE0, 5'd7);
    apply(2'd2, 32'h8000_0001, 1'b0, 32'h1234_5661, 5'd3);
    apply(2'd1, 32'h8000_0000, 1'b1, 32'h0000_0004, 5'd31);
    // R2: sign fill on negative and positive operands, full range
    apply(2'd1, 32'hF000_0000, 1'b0, 32'd31, 5'd0);
    apply(2'd1, 32'h7FFF_FFFF, 1'b1, 32'd0, 5'd31);
    // R5: carry at both ends; R8: zero result
    apply(2'd2, 32'h0000_0001, 1'b1, 32'd0, 5'd31);
    apply(2'd0, 32'h8000_0000, 1'b1, 32'd0, 5'd31);
    apply(2'd2, 32'h0000_0002, 1'b1, 32'd0, 5'd31);
    // R9: reserved op with nonzero amounts
    apply(2'd3, 32'hDEAD_BEEF, 1'b1, 32'd0, 5'd17);
    apply(2'd3, 32'h0000_0000, 1'b0, 32'd9, 5'd0);
    // every amount, every op, both sources
    for (int a = 0; a < 32; a++)
      for (int op = 0; op < 3; op++) begin
        apply(2'(op), 32'hC3A5_5A3C, 1'b1, 32'hFFFF_FFFF, 5'(a));
        apply(2'(op), 32'h3C5A_A5C3, 1'b0, {27'h5A5A5A5, 5'(a)}, 5'(~a));
      end
    // constrained random
    for (int i = 0; i < 3000; i++)
      apply(2'($urandom_range(0, 3)), $urandom(), 1'($urandom()), $urandom(),
            5'($urandom()));
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule